// File: doc/BRIEF.md
# Pin Edge Event Interrupt Controller

This block watches a parameterised bank of general-purpose input pins and records programmed signal transitions. Each pin has an enable for low-to-high transitions and a separate enable for high-to-low transitions. When an enabled transition is seen, the pin's event bit is set and stays set until software writes a one to that bit.

Pin 0 and pin 1 each have their own interrupt line. The event bits of all higher pins are combined into one shared interrupt, and software then reads the event words to find the source. Each pin input is synchronised to the block clock before it is compared with its previous sample. Software reaches the registers through a simple bus: one write port and one combinational read port. The registers are grouped in words of `WORD_W` bits. Pin p sits in word p / WORD_W, at bit p % WORD_W.

Top module: `gpio_edge_irq`

## Requirements
- R1: A low-to-high transition on a pin whose rise-enable bit is set makes that pin's event bit set. The rise-enable word is at address {2'b00, word}. With the defaults (72 pins, 32-bit words, 4-bit address), pin 40 is word 1, bit 8.
- R2: A high-to-low transition on a pin whose fall-enable bit is set makes that pin's event bit set. The fall-enable word is at address {2'b01, word}. A transition in the direction that is not enabled leaves the event bit at 0.
- R3: When both enable bits of a pin are set, a transition in either direction sets that pin's event bit.
- R4: When both enable bits of a pin are clear, transitions on that pin never set its event bit. Clearing both bits masks the pin.
- R5: The event word is at address {2'b10, word}. Event bits hold until cleared. Writing 1 to an event bit clears it and writing 0 leaves it unchanged, so writing back the value just read clears every bit that was set.
- R6: If a transition sets a bit in the same cycle as a write-one-to-clear of that bit, the bit ends up set.
- R7: The irq_pin0_o and irq_pin1_o outputs are registered copies of the event bits of pins 0 and 1. Each follows its bit one clock later.
- R8: The irq_sum_o output is registered one clock after the OR of the event bits of pins 2 and above. The event bits of pins 0 and 1 do not affect it.
- R9: After reset, every enable word, every event word and every interrupt output is 0. Reads with selector 2'b11, and reads of a word index past the last word, return 0.
- R10: A pin change first sampled at clock edge k is visible in the event word after clock edge k+2, and not after clock edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | NUM_PINS | Asynchronous pin inputs |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Write address: {selector[1:0], word index} |
| wr_data_i | input | WORD_W | Write data |
| rd_addr_i | input | ADDR_W | Read address, same layout as write address |
| rd_data_o | output | WORD_W | Combinational read data |
| irq_pin0_o | output | 1 | Dedicated interrupt for pin 0 |
| irq_pin1_o | output | 1 | Dedicated interrupt for pin 1 |
| irq_sum_o | output | 1 | Shared interrupt for pins 2 and above |

## Verification
The checker looks at every cycle for five properties: event bits hold between clears, a masked pin never gains an event bit, a write-one-to-clear on word 0 clears its bits unless they are set again in that cycle, fresh events always land, and the three interrupt outputs follow the event bits with one cycle of delay. Other behaviour depends on a planned sequence of stimulus, so only the bench scenarios can show it. This covers the exact two-edge latency from a sampled pin change, the difference between rising and falling enables, the set-wins collision, the write-back clear of a word just read, and the exclusion of pins 0 and 1 from the shared line. A behavioural reference model also compares all outputs and the addressed read word on every cycle.

// File: rtl/gei_pkg.sv
package gei_pkg;
   typedef enum logic [1:0] {
      SEL_RISE = 2'd0,
      SEL_FALL = 2'd1,
      SEL_STAT = 2'd2,
      SEL_NONE = 2'd3
   } gei_sel_e;

   function automatic int idx_width(input int nwords);
      return (nwords > 1) ? $clog2(nwords) : 1;
   endfunction
endpackage

// File: rtl/gei_sync_edge.sv
module gei_sync_edge #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] rise_o,
   output logic [W-1:0] fall_o
);
   logic [W-1:0] stg_q [STAGES];
   logic [W-1:0] prev_q;

   if (STAGES < 2) begin : g_bad_stages
      $error("gei_sync_edge: STAGES must be at least 2");
   end

   for (genvar s = 0; s < STAGES; s++) begin : g_stg
      if (s == 0) begin : g_first
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) stg_q[s] <= '0;
            else         stg_q[s] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) stg_q[s] <= '0;
            else         stg_q[s] <= stg_q[s-1];
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q <= '0;
      else         prev_q <= stg_q[STAGES-1];
   end

   assign rise_o = stg_q[STAGES-1] & ~prev_q;
   assign fall_o = ~stg_q[STAGES-1] & prev_q;
endmodule

// File: rtl/gei_word_regs.sv
module gei_word_regs #(
   parameter int           W     = 32,
   parameter logic [W-1:0] VALID = '1
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         wr_rise_i,
   input  logic         wr_fall_i,
   input  logic         wr_stat_i,
   input  logic [W-1:0] wdata_i,
   input  logic [W-1:0] rise_evt_i,
   input  logic [W-1:0] fall_evt_i,
   output logic [W-1:0] rise_en_o,
   output logic [W-1:0] fall_en_o,
   output logic [W-1:0] stat_o,
   output logic [W-1:0] set_o
);
   logic [W-1:0] clr;

   assign set_o = ((rise_evt_i & rise_en_o) | (fall_evt_i & fall_en_o)) & VALID;
   assign clr   = wr_stat_i ? wdata_i : '0;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rise_en_o <= '0;
         fall_en_o <= '0;
         stat_o    <= '0;
      end else begin
         if (wr_rise_i) rise_en_o <= wdata_i & VALID;
         if (wr_fall_i) fall_en_o <= wdata_i & VALID;
         stat_o <= (stat_o & ~clr) | set_o;
      end
   end
endmodule

// File: rtl/gei_irq_out.sv
module gei_irq_out #(
   parameter int PW = 64
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic [PW-1:0] stat_i,
   output logic [1:0]    ded_o,
   output logic          sum_o
);
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ded_o <= '0;
         sum_o <= 1'b0;
      end else begin
         ded_o <= stat_i[1:0];
         sum_o <= |stat_i[PW-1:2];
      end
   end
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq
   import gei_pkg::*;
#(
   parameter int NUM_PINS    = 72,
   parameter int WORD_W      = 32,
   parameter int SYNC_STAGES = 2,
   parameter int NWORDS      = (NUM_PINS + WORD_W - 1) / WORD_W,
   parameter int WIDX_W      = idx_width(NWORDS),
   parameter int ADDR_W      = WIDX_W + 2
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic [NUM_PINS-1:0] pin_i,
   input  logic                wr_en_i,
   input  logic [ADDR_W-1:0]   wr_addr_i,
   input  logic [WORD_W-1:0]   wr_data_i,
   input  logic [ADDR_W-1:0]   rd_addr_i,
   output logic [WORD_W-1:0]   rd_data_o,
   output logic                irq_pin0_o,
   output logic                irq_pin1_o,
   output logic                irq_sum_o
);
   localparam int PW = NWORDS * WORD_W;

   if (NUM_PINS < 3 || NUM_PINS > 128) begin : g_bad_pins
      $error("gpio_edge_irq: NUM_PINS must be within 3..128");
   end
   if (WORD_W < 8 || WORD_W > 32) begin : g_bad_word
      $error("gpio_edge_irq: WORD_W must be within 8..32");
   end

   logic [PW-1:0] pin_pad;
   logic [PW-1:0] rise_evt, fall_evt;
   logic [NWORDS-1:0][WORD_W-1:0] ren_w, fen_w, stat_w, set_w;
   logic [PW-1:0] stat_flat, set_flat, ren_flat, fen_flat;
   logic [1:0]    ded;

   gei_sel_e            wr_sel, rd_sel;
   logic [WIDX_W-1:0]   wr_idx, rd_idx;

   assign pin_pad = PW'(pin_i);
   assign wr_sel  = gei_sel_e'(wr_addr_i[ADDR_W-1 -: 2]);
   assign wr_idx  = wr_addr_i[WIDX_W-1:0];
   assign rd_sel  = gei_sel_e'(rd_addr_i[ADDR_W-1 -: 2]);
   assign rd_idx  = rd_addr_i[WIDX_W-1:0];

   gei_sync_edge #(.W(PW), .STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (pin_pad),
      .rise_o (rise_evt),
      .fall_o (fall_evt)
   );

   for (genvar w = 0; w < NWORDS; w++) begin : g_word
      localparam int NV = ((NUM_PINS - w * WORD_W) >= WORD_W) ? WORD_W
                                                             : (NUM_PINS - w * WORD_W);
      localparam logic [WORD_W-1:0] VM = WORD_W'((64'd1 << NV) - 64'd1);
      logic hit;
      assign hit = wr_en_i && (int'(wr_idx) == w);

      gei_word_regs #(.W(WORD_W), .VALID(VM)) u_regs (
         .clk_i      (clk_i),
         .rst_ni     (rst_ni),
         .wr_rise_i  (hit && wr_sel == SEL_RISE),
         .wr_fall_i  (hit && wr_sel == SEL_FALL),
         .wr_stat_i  (hit && wr_sel == SEL_STAT),
         .wdata_i    (wr_data_i),
         .rise_evt_i (rise_evt[w*WORD_W +: WORD_W]),
         .fall_evt_i (fall_evt[w*WORD_W +: WORD_W]),
         .rise_en_o  (ren_w[w]),
         .fall_en_o  (fen_w[w]),
         .stat_o     (stat_w[w]),
         .set_o      (set_w[w])
      );
   end

   assign stat_flat = stat_w;
   assign set_flat  = set_w;
   assign ren_flat  = ren_w;
   assign fen_flat  = fen_w;

   always_comb begin
      rd_data_o = '0;
      if (int'(rd_idx) < NWORDS) begin
         unique case (rd_sel)
            SEL_RISE: rd_data_o = ren_w[rd_idx];
            SEL_FALL: rd_data_o = fen_w[rd_idx];
            SEL_STAT: rd_data_o = stat_w[rd_idx];
            default:  rd_data_o = '0;
         endcase
      end
   end

   gei_irq_out #(.PW(PW)) u_irq (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .stat_i (stat_flat),
      .ded_o  (ded),
      .sum_o  (irq_sum_o)
   );

   assign irq_pin0_o = ded[0];
   assign irq_pin1_o = ded[1];
endmodule

// File: rtl/gei_checker.sv
module gei_checker #(
   parameter int PW     = 96,
   parameter int WORD_W = 32,
   parameter int WIDX_W = 2,
   parameter int ADDR_W = 4
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              wr_en_i,
   input logic [ADDR_W-1:0] wr_addr_i,
   input logic [WORD_W-1:0] wr_data_i,
   input logic [PW-1:0]     stat_i,
   input logic [PW-1:0]     set_i,
   input logic [PW-1:0]     ren_i,
   input logic [PW-1:0]     fen_i,
   input logic              irq_pin0_o,
   input logic              irq_pin1_o,
   input logic              irq_sum_o
);
   logic stat_wr, stat_wr0;
   assign stat_wr  = wr_en_i && (wr_addr_i[ADDR_W-1 -: 2] == 2'd2);
   assign stat_wr0 = stat_wr && (wr_addr_i[WIDX_W-1:0] == '0);

   // R5: without a write to an event word, no event bit drops
   p_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !stat_wr |=> (($past(stat_i) & ~stat_i) == '0));

   // R5: ones written to event word 0 clear those bits unless set again
   p_w1c_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stat_wr0 |=> ((stat_i[WORD_W-1:0] &
                     $past(wr_data_i & ~set_i[WORD_W-1:0])) == '0));

   // R4: a pin with neither enable never gains an event bit
   p_mask_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> (((stat_i & ~$past(stat_i)) & ~($past(ren_i) | $past(fen_i))) == '0));

   // R6: a fresh event always lands, even against a clear
   p_set_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|set_i) |=> ((stat_i & $past(set_i)) == $past(set_i)));

   // R7: dedicated lines follow their event bits one clock later
   p_ded_follow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> (irq_pin0_o == $past(stat_i[0]) && irq_pin1_o == $past(stat_i[1])));

   // R8: shared line follows the OR of pins 2 and up one clock later
   p_sum_follow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> (irq_sum_o == $past(|stat_i[PW-1:2])));
endmodule

bind gpio_edge_irq gei_checker #(
   .PW(PW), .WORD_W(WORD_W), .WIDX_W(WIDX_W), .ADDR_W(ADDR_W)
) u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .wr_en_i    (wr_en_i),
   .wr_addr_i  (wr_addr_i),
   .wr_data_i  (wr_data_i),
   .stat_i     (stat_flat),
   .set_i      (set_flat),
   .ren_i      (ren_flat),
   .fen_i      (fen_flat),
   .irq_pin0_o (irq_pin0_o),
   .irq_pin1_o (irq_pin1_o),
   .irq_sum_o  (irq_sum_o)
);

// File: tb/sim_gpio_edge_irq.sv
`timescale 1ns/1ps
module sim_gpio_edge_irq;
   localparam int NP = 72;
   localparam int WW = 32;
   localparam int NW = 3;
   localparam int AW = 4;
   localparam int PP = NW * WW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NP-1:0] pin = '0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [WW-1:0] wr_data = '0;
   logic [AW-1:0] rd_addr = '0;
   logic [WW-1:0] rd_data;
   logic          irq0, irq1, irqs;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit started = 1'b0;

   always #4 clk = ~clk;

   gpio_edge_irq #(.NUM_PINS(NP), .WORD_W(WW)) u0 (
      .clk_i(clk), .rst_ni(rst_n), .pin_i(pin),
      .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
      .rd_addr_i(rd_addr), .rd_data_o(rd_data),
      .irq_pin0_o(irq0), .irq_pin1_o(irq1), .irq_sum_o(irqs)
   );

   // behavioural reference model
   logic [PP-1:0] m_s1, m_s2, m_prev, m_ren, m_fen, m_stat;
   logic          m_irq0, m_irq1, m_sum;

   always @(posedge clk) begin
      logic [PP-1:0] rise, fall, setv, clrv;
      if (!rst_n) begin
         m_s1 = '0; m_s2 = '0; m_prev = '0; m_ren = '0; m_fen = '0; m_stat = '0;
         m_irq0 = 0; m_irq1 = 0; m_sum = 0;
      end else begin
         rise = m_s2 & ~m_prev;
         fall = ~m_s2 & m_prev;
         setv = (rise & m_ren) | (fall & m_fen);
         clrv = '0;
         m_irq0 = m_stat[0];
         m_irq1 = m_stat[1];
         m_sum  = 1'b0;
         for (int p = 2; p < NP; p++) if (m_stat[p]) m_sum = 1'b1;
         for (int p = 0; p < NP; p++) begin
            if (wr_en && (p / WW) == int'(wr_addr[1:0])) begin
               case (wr_addr[3:2])
                  2'd0: m_ren[p] = wr_data[p % WW];
                  2'd1: m_fen[p] = wr_data[p % WW];
                  2'd2: clrv[p]  = wr_data[p % WW];
                  default: ;
               endcase
            end
         end
         m_stat = (m_stat & ~clrv) | setv;
         m_prev = m_s2;
         m_s2   = m_s1;
         m_s1   = PP'(pin);
      end
   end

   function automatic logic [WW-1:0] mread(input logic [AW-1:0] a);
      logic [WW-1:0] r = '0;
      for (int b = 0; b < WW; b++) begin
         int p = int'(a[1:0]) * WW + b;
         if (int'(a[1:0]) < NW && p < NP) begin
            case (a[3:2])
               2'd0: r[b] = m_ren[p];
               2'd1: r[b] = m_fen[p];
               2'd2: r[b] = m_stat[p];
               default: r[b] = 1'b0;
            endcase
         end
      end
      return r;
   endfunction

   task automatic chk(input string req, input string what,
                      input logic [WW-1:0] act, input logic [WW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // cycle-by-cycle comparison against the model
   always @(negedge clk) begin
      if (started) begin
         chk("R7", "irq_pin0 vs model", WW'(irq0), WW'(m_irq0));
         chk("R7", "irq_pin1 vs model", WW'(irq1), WW'(m_irq1));
         chk("R8", "irq_sum vs model",  WW'(irqs), WW'(m_sum));
         chk("R1", "read word vs model", rd_data, mread(rd_addr));
      end
   end

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic wr(input logic [1:0] sel, input logic [1:0] idx, input logic [WW-1:0] d);
      @(posedge clk); #1;
      wr_en = 1'b1; wr_addr = {sel, idx}; wr_data = d;
      @(posedge clk); #1;
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] sel, input logic [1:0] idx, output logic [WW-1:0] d);
      rd_addr = {sel, idx};
      @(negedge clk);
      d = rd_data;
   endtask

   task automatic setpin(input int p, input logic v);
      @(posedge clk); #1;
      pin[p] = v;
   endtask

   initial begin : watchdog
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
         end
      end
   end

   initial begin : stim
      logic [WW-1:0] d, d0, d1;
      step(3);
      started = 1'b1;
      step(1);
      rst_n = 1'b1;
      step(1);

      // R9 reset state
      for (int s = 0; s < 3; s++)
         for (int w = 0; w < NW; w++) begin
            rd(2'(s), 2'(w), d);
            chk("R9", "register zero after reset", d, '0);
         end
      chk("R9", "irq outputs after reset", WW'({irq0, irq1, irqs}), '0);

      // R1 rising on pin 0, dedicated line R7
      wr(2'd0, 2'd0, 32'h1);
      setpin(0, 1'b1);
      step(4);
      rd(2'd2, 2'd0, d);
      chk("R1", "event after rise on pin0", d, 32'h1);
      chk("R7", "irq_pin0 raised", WW'(irq0), 32'h1);
      chk("R8", "sum excludes pin0", WW'(irqs), 32'h0);
      setpin(0, 1'b0);
      step(4);
      // R5 writing zero leaves bit, writing one clears
      wr(2'd2, 2'd0, 32'h0);
      rd(2'd2, 2'd0, d);
      chk("R5", "zero write keeps bit", d, 32'h1);
      wr(2'd2, 2'd0, 32'h1);
      rd(2'd2, 2'd0, d);
      chk("R5", "one write clears bit", d, 32'h0);
      step(1);
      chk("R7", "irq_pin0 dropped", WW'(irq0), 32'h0);

      // R2 falling only on pin 1
      wr(2'd1, 2'd0, 32'h2);
      setpin(1, 1'b1);
      step(4);
      rd(2'd2, 2'd0, d);
      chk("R2", "rise ignored with fall enable", d, 32'h0);
      setpin(1, 1'b0);
      step(4);
      rd(2'd2, 2'd0, d);
      chk("R2", "event after fall on pin1", d, 32'h2);
      chk("R7", "irq_pin1 raised", WW'(irq1), 32'h1);
      chk("R8", "sum excludes pin1", WW'(irqs), 32'h0);

      // R3 both edges on pin 40 (word 1 bit 8), shared line R8
      wr(2'd0, 2'd1, 32'h100);
      wr(2'd1, 2'd1, 32'h100);
      setpin(40, 1'b1);
      step(4);
      rd(2'd2, 2'd1, d);
      chk("R3", "rise sets with both enables", d, 32'h100);
      chk("R8", "sum raised by pin40", WW'(irqs), 32'h1);
      wr(2'd2, 2'd1, 32'h100);
      setpin(40, 1'b0);
      step(4);
      rd(2'd2, 2'd1, d);
      chk("R3", "fall sets with both enables", d, 32'h100);

      // R5 write back what was read clears everything
      rd(2'd2, 2'd0, d0);
      rd(2'd2, 2'd1, d1);
      wr(2'd2, 2'd0, d0);
      wr(2'd2, 2'd1, d1);
      rd(2'd2, 2'd0, d);
      chk("R5", "write-back clears word0", d, 32'h0);
      rd(2'd2, 2'd1, d);
      chk("R5", "write-back clears word1", d, 32'h0);
      step(2);
      chk("R8", "sum dropped", WW'(irqs), 32'h0);

      // R4 masking: pin 5 never enabled, pin 40 enables cleared
      wr(2'd0, 2'd1, 32'h0);
      wr(2'd1, 2'd1, 32'h0);
      setpin(5, 1'b1);
      setpin(40, 1'b1);
      step(4);
      setpin(5, 1'b0);
      setpin(40, 1'b0);
      step(4);
      rd(2'd2, 2'd0, d);
      chk("R4", "masked pin5 no event", d, 32'h0);
      rd(2'd2, 2'd1, d);
      chk("R4", "masked pin40 no event", d, 32'h0);
      chk("R4", "no shared irq when masked", WW'(irqs), 32'h0);

      // R6 set wins over a same-cycle clear, pin 70 = word 2 bit 6
      wr(2'd0, 2'd2, 32'h40);
      setpin(70, 1'b1);
      step(2);
      wr_en = 1'b1; wr_addr = {2'd2, 2'd2}; wr_data = 32'h40;
      step(1);
      wr_en = 1'b0;
      rd(2'd2, 2'd2, d);
      chk("R6", "set beats clear", d, 32'h40);
      wr(2'd2, 2'd2, 32'h40);
      rd(2'd2, 2'd2, d);
      chk("R5", "pin70 cleared", d, 32'h0);

      // R10 latency on falling pin 70
      wr(2'd1, 2'd2, 32'h40);
      setpin(70, 1'b0);
      step(1);
      rd(2'd2, 2'd2, d);
      chk("R10", "not visible after first edge", d, 32'h0);
      step(1);
      rd(2'd2, 2'd2, d);
      chk("R10", "not visible after second edge", d, 32'h0);
      step(1);
      rd(2'd2, 2'd2, d);
      chk("R10", "visible after third edge", d, 32'h40);

      // R9 unused selector and out-of-range word read zero
      rd(2'd3, 2'd0, d);
      chk("R9", "selector 3 reads zero", d, 32'h0);
      rd(2'd2, 2'd3, d);
      chk("R9", "word 3 reads zero", d, 32'h0);

      step(4);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule